// File: doc/BRIEF.md
# Display Pipe Event Status Register

This block holds one display pipe's event bookkeeping in a single 32-bit word. Hardware timing pulses, such as vertical blank and start of vertical blank, set sticky status bits. Software controls which of those status bits may raise the pipe's event line by writing enable bits. Each enable sits exactly 16 positions above the status bit it gates. Status bits are cleared by writing ones to them.

Because of this layout, one write can switch a source on and discard its stale pending status in the same cycle. Writing back a value that was just read acknowledges everything that was pending. The block reduces the enabled, pending status to one level-type event line that feeds an interrupt controller. A chip places one instance per display pipe.

Top module: `pipe_event_status`

## Requirements
- R1: A synchronous active-low reset clears every enable and every status bit. After reset, `reg_rdata` reads 0 and `pipe_evt` is low.
- R2: A pulse on `hw_evt[k]` sets a status bit on the next clock edge, whether or not that bit is enabled. For k = 0..15 the bit is `reg_rdata[k]`. For k = 16 the bit is `reg_rdata[31]`.
- R3: A write (`reg_wr` high) loads `reg_wdata[30:16]` into the enables, and `reg_rdata[30:16]` returns them as written. Reading has no side effect, and idle cycles leave the whole word unchanged.
- R4: Status bits 15:0 and 31 are write-one-to-clear. Writing 1 clears the bit. Writing 0 leaves it as it was.
- R5: Writing back the value just read clears every status bit that was set and leaves the enables equal to the written upper half.
- R6: A single write that sets enable n+16 and writes 1 to status bit n leaves the enable set, clears the status bit, and keeps `pipe_evt` low.
- R7: Writing 0 turns off all enables and leaves pending status bits set. `pipe_evt` then goes low.
- R8: `pipe_evt` is the OR, over n = 0..14, of status bit n AND enable bit n+16. Status bits 15 and 31 have no enable partner and never drive `pipe_evt`.
- R9: If a hardware pulse and a write-one-to-clear hit the same status bit in one cycle, the bit ends up set.
- R10: Vertical blank (status bit 1, enable bit 17) and start of vertical blank (status bit 2, enable bit 18) are independent sources. Each drives `pipe_evt` only through its own enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register word |
| reg_wdata | input | 32 | Write data: enables in 30:16, clear ones in 15:0 and 31 |
| hw_evt | input | 17 | Hardware event pulses; index 16 maps to bit 31 |
| reg_rdata | output | 32 | Current register word |
| pipe_evt | output | 1 | OR of the enabled, pending status bits |

## Verification
A hardware pulse and a software write-one-to-clear can land on the same status bit in the same cycle. The bench provokes this by raising `hw_evt` for a bit while writing a 1 to that bit. It judges the result by whether the bit reads back set on the following cycle and whether `pipe_evt` follows. A write that sets an enable together with a clear of its paired status can also coincide with a fresh pulse on a different bit. A reference model steps alongside the design, and the full read word and the event line are compared after every clock.

// File: rtl/pes_pkg.sv
// Package: shared constants for the pipe event status register.
// Assumes a word of two equal halves; enables live in the upper half.
package pes_pkg;
    localparam int unsigned PES_HALF_W  = 16;
    localparam int unsigned VBLANK_IDX  = 1;
    localparam int unsigned VSTART_IDX  = 2;
endpackage

// File: rtl/pes_status_bit.sv
// Module: one sticky status bit.
// A set pulse has priority over a write-one-to-clear in the same cycle.
// Assumes synchronous active-low reset.
module pes_status_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // Latch on event, clear on request, set wins a collision.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= 1'b0;
        else if (set_i)  q_o <= 1'b1;
        else if (clr_i)  q_o <= 1'b0;
    end
endmodule

// File: rtl/pes_enable_bank.sv
// Module: register for the enable half of the word.
// Loaded wholesale on every write; holds otherwise.
module pes_enable_bank #(
    parameter int unsigned W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Capture the written enables.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end
endmodule

// File: rtl/pes_event_reduce.sv
// Module: reduces gated status bits to a single event line.
// Assumes status and enable vectors are aligned bit for bit.
module pes_event_reduce #(
    parameter int unsigned W = 15
) (
    input  logic [W-1:0] st_i,
    input  logic [W-1:0] en_i,
    output logic         evt_o
);
    // OR of all enabled pending bits.
    always_comb begin
        evt_o = 1'b0;
        for (int i = 0; i < int'(W); i++) evt_o = evt_o | (st_i[i] & en_i[i]);
    end
endmodule

// File: rtl/pipe_event_status.sv
// Module: per-pipe event status register (top).
// Status bits sit in the low half and in the top bit; each enable sits a
// half-word above its status partner. The top status bit and the highest
// low-half status bit have no enable. Reads are free of side effects.
module pipe_event_status #(
    parameter int unsigned HALF_W = pes_pkg::PES_HALF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [2*HALF_W-1:0] reg_wdata,
    input  logic [HALF_W:0]     hw_evt,
    output logic [2*HALF_W-1:0] reg_rdata,
    output logic                pipe_evt
);
    localparam int unsigned WORD_W = 2 * HALF_W;
    localparam int unsigned SRC_N  = HALF_W + 1;
    localparam int unsigned EN_N   = HALF_W - 1;

    logic [SRC_N-1:0] st_vec;
    logic [EN_N-1:0]  en_vec;

    // One sticky cell per status source, mapped to its word position.
    for (genvar k = 0; k < SRC_N; k++) begin : g_st
        localparam int unsigned POS = (k < HALF_W) ? k : WORD_W - 1;
        pes_status_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (hw_evt[k]),
            .clr_i (reg_wr & reg_wdata[POS]),
            .q_o   (st_vec[k])
        );
    end

    pes_enable_bank #(.W(EN_N)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (reg_wr),
        .d_i    (reg_wdata[WORD_W-2:HALF_W]),
        .q_o    (en_vec)
    );

    pes_event_reduce #(.W(EN_N)) u_red (
        .st_i  (st_vec[EN_N-1:0]),
        .en_i  (en_vec),
        .evt_o (pipe_evt)
    );

    // Assemble the read word from status and enables.
    always_comb begin
        reg_rdata                    = '0;
        reg_rdata[HALF_W-1:0]        = st_vec[HALF_W-1:0];
        reg_rdata[WORD_W-2:HALF_W]   = en_vec;
        reg_rdata[WORD_W-1]          = st_vec[HALF_W];
    end
endmodule

// File: rtl/pipe_event_status_chk.sv
// Module: assertion checker for pipe_event_status, attached by bind.
module pipe_event_status_chk #(
    parameter int unsigned HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [2*HALF_W-1:0] reg_wdata,
    input logic [HALF_W:0]     hw_evt,
    input logic [2*HALF_W-1:0] reg_rdata,
    input logic                pipe_evt
);
    localparam int unsigned WORD_W = 2 * HALF_W;
    logic [HALF_W:0]   st;
    logic [HALF_W-2:0] en;
    assign st = {reg_rdata[WORD_W-1], reg_rdata[HALF_W-1:0]};
    assign en = reg_rdata[WORD_W-2:HALF_W];

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == '0 && !pipe_evt));

    // R2 and R9: a pulse always leaves its bit set.
    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_evt) |=> ((st & $past(hw_evt)) == $past(hw_evt)));

    p_wr_loads_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (en == $past(reg_wdata[WORD_W-2:HALF_W])));

    p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && hw_evt == '0) |=> $stable(reg_rdata));

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ((st & $past(st)) == $past(st)));

    p_evt_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_evt == (|(st[HALF_W-2:0] & en)));
endmodule

bind pipe_event_status pipe_event_status_chk #(.HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .hw_evt    (hw_evt),
    .reg_rdata (reg_rdata),
    .pipe_evt  (pipe_evt)
);

// File: tb/tb_pipe_event_status.sv
// Bench: behavioural reference model stepped with the design and compared
// after every clock edge.
module tb_pipe_event_status;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [16:0] hw_evt = '0;
    logic [31:0] reg_rdata;
    logic        pipe_evt;

    int checks = 0;
    int fails = 0;
    logic [31:0] model = '0;
    bit done = 0;

    localparam logic [31:0] ST_MASK = 32'h8000_FFFF;

    always #5 clk = ~clk;

    pipe_event_status dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .hw_evt(hw_evt), .reg_rdata(reg_rdata), .pipe_evt(pipe_evt)
    );

    function automatic logic model_evt(input logic [31:0] w);
        return |(w[14:0] & w[30:16]);
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (reg_rdata !== model || pipe_evt !== model_evt(model)) begin
            fails++;
            $display("FAIL %s rdata=%h evt=%b expected rdata=%h evt=%b",
                     tag, reg_rdata, pipe_evt, model, model_evt(model));
        end
    endtask

    // Drive one cycle, advance the model, compare after the edge.
    task automatic step(input logic wr, input logic [31:0] wd,
                        input logic [16:0] ev, input string tag);
        logic [31:0] setm, clrm, nxt;
        reg_wr = wr; reg_wdata = wd; hw_evt = ev;
        setm = {ev[16], 15'b0, ev[15:0]};
        clrm = wr ? (wd & ST_MASK) : 32'h0;
        nxt  = (model & ST_MASK & ~clrm) | setm;
        nxt[30:16] = wr ? wd[30:16] : model[30:16];
        @(posedge clk);
        model = nxt;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; hw_evt = '0;
        compare(tag);
    endtask

    task automatic expect_evt(input logic v, input string tag);
        checks++;
        if (pipe_evt !== v) begin
            fails++;
            $display("FAIL %s evt=%b expected %b", tag, pipe_evt, v);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        step(0, 0, 0, "R1 idle after reset");
        // R2: unenabled pulses still latch, including the top bit.
        step(0, 0, 17'h00002, "R2 vblank latch without enable");
        step(0, 0, 17'h10000, "R2 top bit latch");
        // R3: idle reads leave word intact.
        step(0, 0, 0, "R3 read no side effect");
        step(0, 0, 0, "R3 read no side effect again");
        // R6: enable vblank and clear its stale status together.
        step(1, 32'h0002_0002, 0, "R6 enable with stale clear");
        expect_evt(1'b0, "R6 event stays low");
        // R10: start-of-vblank pulse, not enabled, no event.
        step(0, 0, 17'h00004, "R10 vstart unenabled");
        expect_evt(1'b0, "R10 vstart gated off");
        step(0, 0, 17'h00002, "R10 vblank enabled");
        expect_evt(1'b1, "R10 vblank drives event");
        // R4: writing zeros on status keeps bits; one bit cleared by a one.
        step(1, 32'h0002_0000, 0, "R4 zero write keeps status");
        step(1, 32'h0002_0004, 0, "R4 clear single bit");
        // R8: bits 15 and 31 never drive the event line.
        step(1, 32'h7FFF_0002, 17'h08000, "R8 bit15 set all enables");
        expect_evt(1'b0, "R8 bit15 and bit31 excluded");
        step(0, 0, 17'h00400, "R8 enabled bit10");
        expect_evt(1'b1, "R8 bit10 drives event");
        // R7: writing zero turns enables off, status stays.
        step(1, 32'h0, 0, "R7 zero write");
        expect_evt(1'b0, "R7 event off");
        // R5: write back what was read.
        step(0, 0, 17'h1002F, "R5 load several status");
        step(1, 32'h0005_0000 | reg_rdata, 0, "R5 write-back clears");
        // R9: collision of pulse and clear on same bit.
        step(0, 0, 17'h00008, "R9 prepare bit3");
        step(1, 32'h0008_0008, 17'h00008, "R9 set wins over clear");
        expect_evt(1'b1, "R9 event follows");
        step(1, 32'h8000_0001, 17'h10001, "R9 top bit and bit0 collision");
        for (int i = 0; i < 20; i++)
            step(i[0], {i[3:0], 12'h0, i[3:0], 12'h5}, 17'(i * 37), "R4 mixed traffic");
        rst_n = 1'b0;
        @(posedge clk); model = '0; @(negedge clk);
        compare("R1 reset mid-run");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule